// File: doc/BRIEF.md
# Channel Utilization Percentage Calculator

This block turns five free-running hardware counters into busy percentages over the interval between two sample requests. The counters are total clock cycles, control-channel busy, extension-channel busy, receive-frame time and transmit-frame time. The block keeps the value each counter had at the previous accepted sample. When a new sample strobe arrives, it forms the modulo-2^32 differences. It then reports four figures scaled against the cycle difference.

A fifth figure rates extension-channel activity against the time the control channel was clear, not against total cycles. That figure is clamped to 100.

A single restoring divider produces all quotients one after another, at one quotient bit per clock. A one-cycle done strobe marks new results, and a valid flag tells whether the interval could be measured. A cycle counter that stood still, moved backwards or had no previous snapshot gives an invalid, all-zero result.

Top module: `chan_util_calc`

## Requirements
- R1: After synchronous reset, `valid_o` and `done_o` are 0, every percentage output is 0, and all five snapshots are zero, so the first accepted sample is always invalid.
- R2: An accepted sample whose stored cycle snapshot is zero, or larger than the new cycle count, completes with `valid_o`=0 and all five percentage outputs 0.
- R3: An accepted sample whose cycle count equals the stored cycle snapshot (zero cycle difference) completes invalid with all outputs 0, and no division is started.
- R4: On a valid interval, `pct_ctl_o`, `pct_ext_o`, `pct_rxf_o` and `pct_txf_o` each equal floor(d×100 / dc). Here d is the lane's modulo-2^32 difference and dc is the cycle difference, both formed without overflow. A quotient above 0xFFFFFFFF reports 0xFFFFFFFF.
- R5: The control-clear span is dc minus the control-busy difference when dc is larger, and 0 otherwise. `ext_norm_o` equals floor(extension difference×100 / span), clamped to at most 100. It is exactly 100 when the span is 0.
- R6: Every accepted sample overwrites all five snapshots with the sampled counter values, whether or not its result is valid.
- R7: Each accepted sample produces exactly one single-cycle `done_o` pulse. An invalid sample pulses in the cycle after acceptance, and a valid one within 220 cycles. `valid_o` and the percentages change only in a cycle where `done_o` is high.
- R8: A sample strobe arriving while a computation is in progress is ignored. It changes neither the pending results nor the snapshots used by the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Sample request strobe |
| cyc_cnt_i | input | 32 | Total cycle counter |
| ctl_busy_cnt_i | input | 32 | Control-channel busy counter |
| ext_busy_cnt_i | input | 32 | Extension-channel busy counter |
| rxf_cnt_i | input | 32 | Receive-frame counter |
| txf_cnt_i | input | 32 | Transmit-frame counter |
| pct_ctl_o | output | 32 | Control busy percentage |
| pct_ext_o | output | 32 | Extension busy percentage of total cycles |
| pct_rxf_o | output | 32 | Receive-frame percentage |
| pct_txf_o | output | 32 | Transmit-frame percentage |
| ext_norm_o | output | 32 | Extension busy relative to control-clear time, 0..100 |
| valid_o | output | 1 | Result of last completed sample is valid |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A corrupted snapshot does not show up in the sample that wrote it. It shows in the next sample: a wrong difference gives a wrong percentage, or a spurious valid or invalid verdict. The bench therefore always chains samples and predicts each result from its own copy of the previous counter values.

A divider or sequencing fault shows at the first `done_o` after the fault, as a wrong quotient in one lane or a missing or late strobe. The strobe itself is bounded in time, so a stalled sequencer is reported within one sample period. An ignored strobe that leaks into the state shows as wrong differences on the following sample.

// File: rtl/chan_util_pkg.sv
package chan_util_pkg;
  localparam int CW    = 32;
  localparam int PW    = CW + 8;
  localparam int SCALE = 100;
  localparam int NLANE = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_PUB} cu_state_e;

  function automatic logic [PW-1:0] scale_pct(input logic [CW-1:0] d);
    return PW'(d) * PW'(SCALE);
  endfunction

  function automatic logic [CW-1:0] clear_span(input logic [CW-1:0] cyc_d,
                                               input logic [CW-1:0] ctl_d);
    return (cyc_d > ctl_d) ? (cyc_d - ctl_d) : '0;
  endfunction

  function automatic logic [CW-1:0] clamp_pct(input logic [PW-1:0] q);
    return (q > PW'(SCALE)) ? CW'(SCALE) : q[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] sat_word(input logic [PW-1:0] q);
    return (q > PW'({CW{1'b1}})) ? {CW{1'b1}} : q[CW-1:0];
  endfunction

  function automatic logic interval_ok(input logic [CW-1:0] prev_cyc,
                                       input logic [CW-1:0] new_cyc);
    return (prev_cyc != '0) && (prev_cyc < new_cyc);
  endfunction
endpackage

// File: rtl/cu_snapshot.sv
module cu_snapshot #(
  parameter int CW    = 32,
  parameter int NLANE = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture_i,
  input  logic [NLANE-1:0][CW-1:0]  cnt_i,
  output logic [NLANE-1:0][CW-1:0]  delta_o,
  output logic [CW-1:0]             snap_cyc_o
);
  logic [NLANE-1:0][CW-1:0] snap_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            snap_q[g] <= '0;
      else if (capture_i) snap_q[g] <= cnt_i[g];
    end
    assign delta_o[g] = cnt_i[g] - snap_q[g];
  end

  assign snap_cyc_o = snap_q[0];

  // R6
  snap_load_chk: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (snap_cyc_o == $past(cnt_i[0])));
endmodule

// File: rtl/cu_divider.sv
module cu_divider #(
  parameter int DVD_W = 40,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q;
  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DVS_W:0]   rem_sh, rem_sub;
  logic             fits;

  assign rem_sh  = {rem_q, quo_q[DVD_W-1]};
  assign fits    = rem_sh >= {1'b0, dvs_q};
  assign rem_sub = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0; rem_q <= '0; dvs_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        quo_q  <= dividend_i;
        rem_q  <= '0;
        dvs_q  <= divisor_i;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[DVD_W-2:0], fits};
        rem_q <= fits ? rem_sub[DVS_W-1:0] : rem_sh[DVS_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  // R3
  nonzero_divisor_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (divisor_i != '0));
  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);
endmodule

// File: rtl/chan_util_calc.sv
module chan_util_calc
  import chan_util_pkg::*;
#(
  parameter int CW = chan_util_pkg::CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_i,
  input  logic [CW-1:0] cyc_cnt_i,
  input  logic [CW-1:0] ctl_busy_cnt_i,
  input  logic [CW-1:0] ext_busy_cnt_i,
  input  logic [CW-1:0] rxf_cnt_i,
  input  logic [CW-1:0] txf_cnt_i,
  output logic [CW-1:0] pct_ctl_o,
  output logic [CW-1:0] pct_ext_o,
  output logic [CW-1:0] pct_rxf_o,
  output logic [CW-1:0] pct_txf_o,
  output logic [CW-1:0] ext_norm_o,
  output logic          valid_o,
  output logic          done_o
);
  localparam int NL   = chan_util_pkg::NLANE;
  localparam int PWL  = CW + 8;
  localparam int NPCT = NL - 1;
  localparam int OP_W = $clog2(NL);

  cu_state_e             state_q;
  logic [OP_W-1:0]       op_q;
  logic [NL-1:0][CW-1:0] cnt_bus, delta, dlt_q;
  logic [CW-1:0]         snap_cyc, ccd_q;
  logic [NPCT-1:0][CW-1:0] stage_q, pct_q;
  logic [CW-1:0]         norm_stage_q, norm_q;
  logic                  accept, good_now, valid_q, done_q;
  logic                  div_start, div_busy, div_done;
  logic [PWL-1:0]        div_dvd, div_quot;
  logic [CW-1:0]         div_dvs;

  assign cnt_bus   = {txf_cnt_i, rxf_cnt_i, ext_busy_cnt_i, ctl_busy_cnt_i, cyc_cnt_i};
  assign accept    = sample_i && (state_q == ST_IDLE);
  assign good_now  = interval_ok(snap_cyc, cyc_cnt_i);
  assign div_start = (state_q == ST_LAUNCH);

  cu_snapshot #(.CW(CW), .NLANE(NL)) snap_u (
    .clk(clk), .rst(rst), .capture_i(accept), .cnt_i(cnt_bus),
    .delta_o(delta), .snap_cyc_o(snap_cyc));

  // ops 0..3: lanes 1..4 over cycle delta; op 4: extension over control-clear span
  always_comb begin
    if (op_q < OP_W'(NPCT)) begin
      div_dvd = scale_pct(dlt_q[op_q + 1'b1]);
      div_dvs = dlt_q[0];
    end else begin
      div_dvd = scale_pct(dlt_q[2]);
      div_dvs = ccd_q;
    end
  end

  cu_divider #(.DVD_W(PWL), .DVS_W(CW)) div_u (
    .clk(clk), .rst(rst), .start_i(div_start), .dividend_i(div_dvd),
    .divisor_i(div_dvs), .busy_o(div_busy), .done_o(div_done), .quot_o(div_quot));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE; op_q <= '0;
      dlt_q <= '0; ccd_q <= '0;
      stage_q <= '0; pct_q <= '0;
      norm_stage_q <= '0; norm_q <= '0;
      valid_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dlt_q <= delta;
          ccd_q <= clear_span(delta[0], delta[1]);
          op_q  <= '0;
          if (good_now) begin
            state_q <= ST_LAUNCH;
          end else begin
            pct_q   <= '0;
            norm_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          if (op_q < OP_W'(NPCT)) stage_q[op_q[1:0]] <= sat_word(div_quot);
          if (op_q == OP_W'(NPCT - 1) && ccd_q == '0) begin
            norm_stage_q <= CW'(SCALE);
            state_q      <= ST_PUB;
          end else if (op_q == OP_W'(NPCT)) begin
            norm_stage_q <= clamp_pct(div_quot);
            state_q      <= ST_PUB;
          end else begin
            op_q    <= op_q + 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        ST_PUB: begin
          pct_q   <= stage_q;
          norm_q  <= norm_stage_q;
          valid_q <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pct_ctl_o  = pct_q[0];
  assign pct_ext_o  = pct_q[1];
  assign pct_rxf_o  = pct_q[2];
  assign pct_txf_o  = pct_q[3];
  assign ext_norm_o = norm_q;
  assign valid_o    = valid_q;
  assign done_o     = done_q;

  // R5
  ext_norm_le100_chk: assert property (@(posedge clk) disable iff (rst)
    ext_norm_o <= CW'(SCALE));
  // R2
  invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !valid_o) |-> (pct_q == '0 && ext_norm_o == '0));
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(snap_cyc));
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(valid_o) && $stable(ext_norm_o)));
  // R3
  div_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !div_busy);
endmodule

// File: tb/chan_util_calc_tb_top.sv
module chan_util_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample = 1'b0;
  logic [31:0] c_cyc = '0, c_ctl = '0, c_ext = '0, c_rxf = '0, c_txf = '0;
  logic [31:0] pct_ctl, pct_ext, pct_rxf, pct_txf, ext_norm;
  logic        valid, done;

  int checks = 0;
  int fails  = 0;
  int cyc_total = 0;
  longint unsigned m_snap [5];

  always #4 clk = ~clk;

  chan_util_calc dut_i (
    .clk(clk), .rst(rst), .sample_i(sample),
    .cyc_cnt_i(c_cyc), .ctl_busy_cnt_i(c_ctl), .ext_busy_cnt_i(c_ext),
    .rxf_cnt_i(c_rxf), .txf_cnt_i(c_txf),
    .pct_ctl_o(pct_ctl), .pct_ext_o(pct_ext), .pct_rxf_o(pct_rxf),
    .pct_txf_o(pct_txf), .ext_norm_o(ext_norm), .valid_o(valid), .done_o(done));

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned wdiff(input longint unsigned a, input longint unsigned b);
    return (a - b) & 64'hFFFF_FFFF;
  endfunction

  task automatic do_sample(input string tag, input logic [31:0] v0, v1, v2, v3, v4,
                           input bit intrude);
    longint unsigned d [5];
    longint unsigned e [4];
    longint unsigned en, ccd, q;
    bit ok;
    int n;
    @(negedge clk);
    c_cyc = v0; c_ctl = v1; c_ext = v2; c_rxf = v3; c_txf = v4;
    sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
    d[0] = wdiff(v0, m_snap[0]); d[1] = wdiff(v1, m_snap[1]); d[2] = wdiff(v2, m_snap[2]);
    d[3] = wdiff(v3, m_snap[3]); d[4] = wdiff(v4, m_snap[4]);
    ok = (m_snap[0] != 0) && (m_snap[0] < v0);
    m_snap[0] = v0; m_snap[1] = v1; m_snap[2] = v2; m_snap[3] = v3; m_snap[4] = v4;
    en = 0;
    for (int i = 0; i < 4; i++) e[i] = 0;
    if (ok) begin
      for (int i = 0; i < 4; i++) begin
        q = (d[i+1] * 100) / d[0];
        e[i] = (q > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : q;
      end
      ccd = (d[0] > d[1]) ? d[0] - d[1] : 0;
      if (ccd == 0) en = 100;
      else begin
        en = (d[2] * 100) / ccd;
        if (en > 100) en = 100;
      end
    end
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      if (intrude && n == 6) begin
        c_cyc = 32'h0000_0005; c_ctl = 32'h1234; c_ext = 32'h99; c_rxf = 32'h7; c_txf = 32'h3;
        sample = 1'b1;
      end else sample = 1'b0;
    end
    sample = 1'b0;
    chk({tag, " R7 done seen"}, done, 1);
    if (ok) chk({tag, " R7 latency bound"}, (n <= 220) ? 1 : 0, 1);
    else    chk({tag, " R7 invalid next cycle"}, n, 0);
    chk({tag, " R2 R3 valid"}, valid, ok);
    chk({tag, " R4 ctl"}, pct_ctl, e[0]);
    chk({tag, " R4 ext"}, pct_ext, e[1]);
    chk({tag, " R4 rxf"}, pct_rxf, e[2]);
    chk({tag, " R4 txf"}, pct_txf, e[3]);
    chk({tag, " R5 ext_norm"}, ext_norm, en);
    @(negedge clk);
    chk({tag, " R7 single pulse"}, done, 0);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) m_snap[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", valid, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset pct", pct_ctl | pct_ext | pct_rxf | pct_txf | ext_norm, 0);
    // R1 R2: first sample after reset invalid
    do_sample("first", 32'd5000, 32'd10, 32'd20, 32'd30, 32'd40, 0);
    // R4 R5 R6: normal interval measured from the invalid sample's snapshot
    do_sample("normal", 32'd6000, 32'd260, 32'd120, 32'd530, 32'd90, 0);
    // R2 R6: cycle counter moved backwards
    do_sample("backward", 32'd4000, 32'd300, 32'd130, 32'd600, 32'd100, 0);
    // R6: next interval relative to the backward snapshot
    do_sample("after_back", 32'd4300, 32'd330, 32'd139, 32'd690, 32'd130, 0);
    // R3: zero cycle difference
    do_sample("zero_dc", 32'd4300, 32'd400, 32'd150, 32'd700, 32'd140, 0);
    // R5: control busy exceeds cycles, clear span 0 -> 100
    do_sample("ctl_full", 32'd4400, 32'd550, 32'd157, 32'd750, 32'd150, 0);
    // R5: extension exceeds clear span -> clamp
    do_sample("clamp", 32'd5400, 32'd1450, 32'd457, 32'd800, 32'd160, 0);
    // R4: busy counter wraps modulo 2^32
    do_sample("pre_wrap", 32'd6400, 32'hFFFF_FF00, 32'd500, 32'd900, 32'd170, 0);
    do_sample("wrap", 32'd7400, 32'h0000_0064, 32'd600, 32'd1000, 32'd180, 0);
    // R4: large deltas, product beyond 32 bits
    do_sample("large", 32'h8000_1CE8, 32'h4000_0000, 32'd700, 32'h8000_03E7, 32'd190, 0);
    // R4: quotient saturates
    do_sample("sat", 32'h8000_1CE9, 32'h5000_0000, 32'd701, 32'h8000_03E8, 32'd191, 0);
    // R8: strobe while computing is ignored; following sample checks snapshots
    do_sample("intrude", 32'h8000_2CE9, 32'h5000_0100, 32'd801, 32'h8000_0400, 32'd200, 1);
    do_sample("post_intrude", 32'h8000_3CE9, 32'h5000_0200, 32'd850, 32'h8000_0500, 32'd260, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc_total);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule